// File: doc/BRIEF.md
# Transport Stream PID Filter and Payload Extractor

This block sits behind a channel decoder that delivers an MPEG-2 transport stream one byte per valid cycle. It finds and holds packet alignment on the 0x47 sync byte. It compares each packet's 13-bit packet identifier against a bank of host-written filter slots and throws away every packet that no enabled slot claims. For the packets it keeps, it checks the per-slot continuity counter, strips the four header bytes and any adaptation field, and emits the remaining payload bytes in arrival order.

Every output byte is tagged with the index of the slot that claimed its packet. The first payload byte of a packet also carries the payload-unit-start flag. By convention slot 0 holds the video PID and slot 1 the audio PID. The other slots serve tables, service data and private streams, and the matching logic treats all slots alike. Continuity faults are reported as one-cycle pulses on a per-slot error vector.

Top module: `ts_pid_demux`

## Requirements
- R1: After reset, and after sync loss, nothing is forwarded and `in_sync` is low until three 0x47 bytes have been seen at 188-byte spacing, the first of them on a valid byte with `in_sop` high. The packet that begins at the third of these bytes is the first one processed, and `in_sync` is high from then on.
- R2: While in sync, if a packet-boundary byte is not 0x47, `in_sync` drops, that packet is discarded, and acquisition restarts as in R1. `in_sop` is ignored while in sync.
- R3: The PID is bits 4..0 of byte 1 followed by byte 2. A packet whose PID equals no enabled slot's PID produces no output and no error.
- R4: When several enabled slots hold the same PID, the lowest slot index claims the packet. `out_slot` carries that index on every payload byte of the packet.
- R5: With adaptation control (byte 3 bits 5..4) equal to 01, bytes 4 to 187 are forwarded in order. Each appears on `out_data` with `out_valid` high one cycle after it is sampled at the input.
- R6: With adaptation control 11, byte 4 is a length L, and the next L bytes are skipped before forwarding resumes, so 183−L bytes are forwarded. With 10 or 00, nothing is forwarded.
- R7: `out_pusi` equals header bit 6 of byte 1 on the first forwarded byte of a packet and is low on all others.
- R8: For a claimed packet carrying payload, the 4-bit counter in byte 3 bits 3..0 must equal the slot's previous value plus one, modulo 16. Any other value, except the duplicate case of R9, raises `cc_err[slot]` for one cycle, on the cycle after byte 3 is sampled. The payload is still forwarded and the new value is stored. The first such packet after a slot is written is always accepted.
- R9: One repeat of the previous counter value is a duplicate: its payload is dropped and no error is raised. A second consecutive repeat is an error, as in R8.
- R10: Packets without payload (adaptation control 10 or 00) neither check nor change the slot's counter state.
- R11: A packet with byte 1 bit 7 (transport error) set is dropped entirely. It raises no error and leaves the counter state unchanged.
- R12: A cycle with `cfg_we` high writes `cfg_pid` and `cfg_en` into slot `cfg_slot` and clears that slot's counter history.
- R13: At most one bit of `cc_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Transport stream byte |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_sop | input | 1 | Marks the first byte of a packet (used only during acquisition) |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | 5 | Slot index to write |
| cfg_pid | input | 13 | PID value for the slot |
| cfg_en | input | 1 | Enable for the slot |
| out_valid | output | 1 | Payload byte present |
| out_data | output | 8 | Payload byte |
| out_slot | output | 5 | Index of the claiming slot |
| out_pusi | output | 1 | Payload unit start, on the first payload byte only |
| cc_err | output | 32 | Per-slot continuity error pulse |
| in_sync | output | 1 | Packet alignment held |

## Verification
On every cycle, the checker confirms four things. The error vector is never more than one-hot. Forwarded bytes copy the input byte of the previous cycle, and only while alignment was held. The slot tag stays constant across a run of payload bytes, and the start flag never lasts two cycles. The continuity rules (increments, single duplicates, double repeats, wrap from 15 to 0, untouched state on error-flagged and payload-free packets) depend on history across packets, so only the directed scenarios can show them. The same holds for the three-boundary reacquisition, adaptation-length skipping and the lowest-index priority.

// File: rtl/ts_demux_pkg.sv
package ts_demux_pkg;
    localparam int PID_W   = 13;
    localparam int CC_W    = 4;
    localparam int BYTE_W  = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h47;
    localparam int HDR_LEN = 4;
    // slot roles by convention; matching treats every slot the same
    localparam int VIDEO_SLOT = 0;
    localparam int AUDIO_SLOT = 1;

    typedef enum logic [1:0] {
        AFC_RSVD    = 2'b00,
        AFC_PAYLOAD = 2'b01,
        AFC_ADAPT   = 2'b10,
        AFC_BOTH    = 2'b11
    } afc_e;
endpackage

// File: rtl/ts_sync_tracker.sv
module ts_sync_tracker
    import ts_demux_pkg::*;
#(
    parameter int PKT_LEN   = 188,
    parameter int SYNC_HITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sop,
    input  logic [BYTE_W-1:0]          in_data,
    output logic                       locked,
    output logic                       byte_take,
    output logic [$clog2(PKT_LEN)-1:0] byte_pos
);
    localparam int POS_W = $clog2(PKT_LEN);
    localparam int HIT_W = $clog2(SYNC_HITS + 1);

    typedef struct packed {
        logic             locked;
        logic [HIT_W-1:0] hits;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;
    logic             is_sync;
    logic             at_edge;
    logic [POS_W-1:0] pos_next;

    always_comb begin
        trk_d     = trk_q;
        byte_take = 1'b0;
        is_sync   = (in_data == SYNC_BYTE);
        at_edge   = (trk_q.pos == '0);
        pos_next  = (trk_q.pos == POS_W'(PKT_LEN - 1)) ? '0 : trk_q.pos + 1'b1;
        if (in_valid) begin
            if (trk_q.locked) begin
                if (at_edge && !is_sync) begin
                    trk_d.locked = 1'b0;
                    trk_d.hits   = '0;
                    trk_d.pos    = '0;
                end else begin
                    byte_take = 1'b1;
                    trk_d.pos = pos_next;
                end
            end else if (trk_q.hits == '0) begin
                if (in_sop && is_sync) begin
                    trk_d.hits = HIT_W'(1);
                    trk_d.pos  = POS_W'(1);
                end
            end else if (at_edge) begin
                if (is_sync) begin
                    if (trk_q.hits == HIT_W'(SYNC_HITS - 1)) begin
                        trk_d.locked = 1'b1;
                        trk_d.hits   = '0;
                        byte_take    = 1'b1;
                    end else begin
                        trk_d.hits = trk_q.hits + 1'b1;
                    end
                    trk_d.pos = POS_W'(1);
                end else begin
                    trk_d.hits = '0;
                    trk_d.pos  = '0;
                end
            end else begin
                trk_d.pos = pos_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign locked   = trk_q.locked;
    assign byte_pos = trk_q.pos;
endmodule

// File: rtl/ts_slot_bank.sv
module ts_slot_bank
    import ts_demux_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_SLOTS)-1:0]  cfg_slot,
    input  logic [PID_W-1:0]              cfg_pid,
    input  logic                          cfg_en,
    input  logic [PID_W-1:0]              look_pid,
    output logic                          look_hit,
    output logic [$clog2(NUM_SLOTS)-1:0]  look_slot,
    input  logic                          chk_en,
    input  logic [$clog2(NUM_SLOTS)-1:0]  chk_slot,
    input  logic [CC_W-1:0]               chk_cc,
    output logic                          chk_pass,
    output logic                          chk_err
);
    localparam int SW = $clog2(NUM_SLOTS);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][PID_W-1:0] pid;
        logic [NUM_SLOTS-1:0]            en;
        logic [NUM_SLOTS-1:0][CC_W-1:0]  last;
        logic [NUM_SLOTS-1:0]            seen;
        logic [NUM_SLOTS-1:0]            dup;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = bank_q.en[g] && (bank_q.pid[g] == look_pid);
    end

    // lowest index wins
    always_comb begin
        look_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) look_slot = SW'(i);
        end
    end
    assign look_hit = |hit_vec;

    logic [CC_W-1:0] prev_cc;

    always_comb begin
        bank_d   = bank_q;
        chk_pass = 1'b0;
        chk_err  = 1'b0;
        prev_cc  = bank_q.last[chk_slot];
        if (chk_en) begin
            if (!bank_q.seen[chk_slot]) begin
                chk_pass                = 1'b1;
                bank_d.seen[chk_slot]   = 1'b1;
                bank_d.last[chk_slot]   = chk_cc;
                bank_d.dup[chk_slot]    = 1'b0;
            end else if (chk_cc == prev_cc + 1'b1) begin
                chk_pass                = 1'b1;
                bank_d.last[chk_slot]   = chk_cc;
                bank_d.dup[chk_slot]    = 1'b0;
            end else if (chk_cc == prev_cc && !bank_q.dup[chk_slot]) begin
                bank_d.dup[chk_slot]    = 1'b1;
            end else begin
                chk_pass                = 1'b1;
                chk_err                 = 1'b1;
                bank_d.last[chk_slot]   = chk_cc;
                bank_d.dup[chk_slot]    = 1'b0;
            end
        end
        if (cfg_we) begin
            bank_d.pid[cfg_slot]  = cfg_pid;
            bank_d.en[cfg_slot]   = cfg_en;
            bank_d.seen[cfg_slot] = 1'b0;
            bank_d.dup[cfg_slot]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/ts_pid_demux.sv
module ts_pid_demux
    import ts_demux_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int PKT_LEN   = 188,
    parameter int SYNC_HITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [7:0]                   in_data,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] cfg_slot,
    input  logic [PID_W-1:0]             cfg_pid,
    input  logic                         cfg_en,
    output logic                         out_valid,
    output logic [7:0]                   out_data,
    output logic [$clog2(NUM_SLOTS)-1:0] out_slot,
    output logic                         out_pusi,
    output logic [NUM_SLOTS-1:0]         cc_err,
    output logic                         in_sync
);
    localparam int SW    = $clog2(NUM_SLOTS);
    localparam int POS_W = $clog2(PKT_LEN);
    localparam int HI_W  = PID_W - BYTE_W;

    typedef struct packed {
        logic                 tei;
        logic                 pusi;
        logic [HI_W-1:0]      pid_hi;
        logic                 hit;
        logic [SW-1:0]        slot;
        logic                 pay_ok;
        logic                 need_len;
        logic [BYTE_W-1:0]    skip;
        logic                 first;
        logic                 ovalid;
        logic [BYTE_W-1:0]    odata;
        logic [SW-1:0]        oslot;
        logic                 opusi;
        logic [NUM_SLOTS-1:0] err;
    } prs_t;

    prs_t prs_d, prs_q;

    logic             byte_take;
    logic [POS_W-1:0] byte_pos;
    logic             locked;
    logic [PID_W-1:0] look_pid;
    logic             look_hit;
    logic [SW-1:0]    look_slot;
    logic             chk_en;
    logic             chk_pass;
    logic             chk_err;
    afc_e             afc;

    ts_sync_tracker #(
        .PKT_LEN   (PKT_LEN),
        .SYNC_HITS (SYNC_HITS)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .locked    (locked),
        .byte_take (byte_take),
        .byte_pos  (byte_pos)
    );

    ts_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_pid   (cfg_pid),
        .cfg_en    (cfg_en),
        .look_pid  (look_pid),
        .look_hit  (look_hit),
        .look_slot (look_slot),
        .chk_en    (chk_en),
        .chk_slot  (prs_q.slot),
        .chk_cc    (in_data[CC_W-1:0]),
        .chk_pass  (chk_pass),
        .chk_err   (chk_err)
    );

    assign look_pid = {prs_q.pid_hi, in_data};
    assign afc      = afc_e'(in_data[5:4]);

    always_comb begin
        prs_d        = prs_q;
        prs_d.ovalid = 1'b0;
        prs_d.opusi  = 1'b0;
        prs_d.err    = '0;
        chk_en       = 1'b0;
        if (byte_take) begin
            case (byte_pos)
                POS_W'(0): begin
                    prs_d.hit    = 1'b0;
                    prs_d.pay_ok = 1'b0;
                end
                POS_W'(1): begin
                    prs_d.tei    = in_data[7];
                    prs_d.pusi   = in_data[6];
                    prs_d.pid_hi = in_data[HI_W-1:0];
                end
                POS_W'(2): begin
                    prs_d.hit  = look_hit;
                    prs_d.slot = look_slot;
                end
                POS_W'(HDR_LEN - 1): begin
                    chk_en         = prs_q.hit && !prs_q.tei && in_data[4];
                    prs_d.pay_ok   = chk_en && chk_pass;
                    prs_d.need_len = (afc == AFC_BOTH);
                    prs_d.skip     = '0;
                    prs_d.first    = 1'b1;
                    if (chk_err) prs_d.err[prs_q.slot] = 1'b1;
                end
                default: begin
                    if (prs_q.need_len) begin
                        prs_d.need_len = 1'b0;
                        prs_d.skip     = in_data;
                    end else if (prs_q.skip != '0) begin
                        prs_d.skip = prs_q.skip - 1'b1;
                    end else if (prs_q.pay_ok) begin
                        prs_d.ovalid = 1'b1;
                        prs_d.odata  = in_data;
                        prs_d.oslot  = prs_q.slot;
                        prs_d.opusi  = prs_q.pusi && prs_q.first;
                        prs_d.first  = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prs_q <= '0;
        else        prs_q <= prs_d;
    end

    assign out_valid = prs_q.ovalid;
    assign out_data  = prs_q.odata;
    assign out_slot  = prs_q.oslot;
    assign out_pusi  = prs_q.opusi;
    assign cc_err    = prs_q.err;
    assign in_sync   = locked;
endmodule

// File: rtl/ts_pid_demux_checks.sv
module ts_pid_demux_checks #(
    parameter int NUM_SLOTS = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [7:0]                   in_data,
    input logic                         in_valid,
    input logic                         out_valid,
    input logic [7:0]                   out_data,
    input logic [$clog2(NUM_SLOTS)-1:0] out_slot,
    input logic                         out_pusi,
    input logic [NUM_SLOTS-1:0]         cc_err,
    input logic                         in_sync
);
    a_r13_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc_err));

    a_r5_data_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data)) && $past(in_valid));

    a_r1_out_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_sync));

    a_r2_loss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |=> !out_valid);

    a_r7_pusi_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_pusi |-> out_valid ##1 !out_pusi);

    a_r4_slot_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_slot));

    a_r8_err_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (|cc_err) |-> $past(in_valid) && $past(in_sync));
endmodule

bind ts_pid_demux ts_pid_demux_checks #(.NUM_SLOTS(NUM_SLOTS)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_slot  (out_slot),
    .out_pusi  (out_pusi),
    .cc_err    (cc_err),
    .in_sync   (in_sync)
);

// File: tb/test_ts_pid_demux.sv
`timescale 1ns/1ps
module test_ts_pid_demux;
    localparam int NS = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_slot = '0;
    logic [12:0]   cfg_pid = '0;
    logic          cfg_en = 1'b0;
    logic          out_valid;
    logic [7:0]    out_data;
    logic [SW-1:0] out_slot;
    logic          out_pusi;
    logic [NS-1:0] cc_err;
    logic          in_sync;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]    cap_d [0:255];
    logic [SW-1:0] cap_s [0:255];
    logic          cap_p [0:255];
    int            cap_n = 0;
    logic [NS-1:0] err_acc = '0;

    ts_pid_demux i_ts_pid_demux (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_pid(cfg_pid),
        .cfg_en(cfg_en), .out_valid(out_valid), .out_data(out_data),
        .out_slot(out_slot), .out_pusi(out_pusi), .cc_err(cc_err), .in_sync(in_sync)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (out_valid && cap_n < 256) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_slot;
            cap_p[cap_n] = out_pusi;
            cap_n++;
        end
        err_acc |= cc_err;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_cap();
        @(negedge clk);
        cap_n   = 0;
        err_acc = '0;
    endtask

    task automatic cfg_write(input int slot, input logic [12:0] pid, input bit en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = SW'(slot); cfg_pid = pid; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_pkt(input logic [7:0] sync, input logic [12:0] pid, input bit tei,
                            input bit pusi, input logic [1:0] afc, input logic [3:0] cc,
                            input int alen, input logic [7:0] base);
        for (int p = 0; p < 188; p++) begin
            logic [7:0] b;
            int q;
            q = p - 4;
            if (p == 0)      b = sync;
            else if (p == 1) b = {tei, pusi, 1'b0, pid[12:8]};
            else if (p == 2) b = pid[7:0];
            else if (p == 3) b = {2'b00, afc, cc};
            else if (afc[1]) begin
                if (q == 0)         b = 8'(alen);
                else if (q <= alen) b = 8'hFF;
                else                b = base + 8'(q - 1 - alen);
            end else b = base + 8'(q);
            @(negedge clk);
            in_valid = 1'b1; in_data = b; in_sop = (p == 0);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_pkt(input string tag, input int n, input int slot,
                              input bit pusi, input logic [7:0] base, input logic [NS-1:0] err);
        bit ok = 1;
        int first_bad = 0;
        check(cap_n == n, {tag, " count"}, cap_n, n);
        if (cap_n == n) begin
            for (int i = 0; i < n; i++) begin
                if (ok && (cap_d[i] != base + 8'(i) || cap_s[i] != SW'(slot) ||
                           cap_p[i] != ((i == 0) ? pusi : 1'b0))) begin
                    ok = 0; first_bad = i;
                end
            end
            if (n > 0) check(ok, {tag, " payload/slot/pusi"}, first_bad, 0);
        end
        check(err_acc == err, {tag, " cc_err"}, err_acc, err);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        check(in_sync == 1'b0, "R1 reset in_sync", in_sync, 0);
        check(cc_err == '0, "R13 reset cc_err", cc_err, 0);
    endtask

    task automatic t_acquire();
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 1, 2'b01, 4'd0, 0, 8'h00);
        send_pkt(8'h47, 13'h100, 0, 1, 2'b01, 4'd1, 0, 8'h00);
        check(in_sync == 1'b0, "R1 not yet in sync", in_sync, 0);
        check(cap_n == 0, "R1 nothing before lock", cap_n, 0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 1, 2'b01, 4'd2, 0, 8'h10);
        check(in_sync == 1'b1, "R1 locked", in_sync, 1);
        expect_pkt("R5 R7 video payload", 184, 0, 1, 8'h10, '0);
    endtask

    task automatic t_audio();
        clear_cap();
        send_pkt(8'h47, 13'h101, 0, 0, 2'b01, 4'd5, 0, 8'h80);
        expect_pkt("R5 R7 audio payload", 184, 1, 0, 8'h80, '0);
    endtask

    task automatic t_adapt();
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 1, 2'b11, 4'd3, 10, 8'h33);
        expect_pkt("R6 adapt len 10", 173, 0, 1, 8'h33, '0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b11, 4'd4, 0, 8'h50);
        expect_pkt("R6 adapt len 0", 183, 0, 0, 8'h50, '0);
    endtask

    task automatic t_no_payload();
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 1, 2'b10, 4'd9, 20, 8'h00);
        expect_pkt("R6 R10 adapt only", 0, 0, 0, 8'h00, '0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd5, 0, 8'h60);
        expect_pkt("R10 counter untouched", 184, 0, 0, 8'h60, '0);
    endtask

    task automatic t_filter();
        clear_cap();
        send_pkt(8'h47, 13'h300, 0, 1, 2'b01, 4'd0, 0, 8'h00);
        expect_pkt("R3 unmatched pid", 0, 0, 0, 8'h00, '0);
        clear_cap();
        send_pkt(8'h47, 13'h200, 0, 1, 2'b01, 4'd0, 0, 8'h00);
        expect_pkt("R3 disabled slot", 0, 0, 0, 8'h00, '0);
    endtask

    task automatic t_priority();
        clear_cap();
        send_pkt(8'h47, 13'h0AB, 0, 0, 2'b01, 4'd0, 0, 8'h20);
        expect_pkt("R4 lowest slot wins", 184, 5, 0, 8'h20, '0);
    endtask

    task automatic t_cc();
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd6, 0, 8'h01);
        expect_pkt("R8 increment ok", 184, 0, 0, 8'h01, '0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd6, 0, 8'h02);
        expect_pkt("R9 single duplicate", 0, 0, 0, 8'h00, '0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd6, 0, 8'h03);
        expect_pkt("R9 second repeat", 184, 0, 0, 8'h03, 32'h1);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd8, 0, 8'h04);
        expect_pkt("R8 gap", 184, 0, 0, 8'h04, 32'h1);
        check($countones(err_acc) == 1, "R13 one error bit", $countones(err_acc), 1);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd15, 0, 8'h05);
        expect_pkt("R8 jump to 15", 184, 0, 0, 8'h05, 32'h1);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd0, 0, 8'h06);
        expect_pkt("R8 wrap 15 to 0", 184, 0, 0, 8'h06, '0);
    endtask

    task automatic t_tei();
        clear_cap();
        send_pkt(8'h47, 13'h100, 1, 1, 2'b01, 4'd7, 0, 8'h00);
        expect_pkt("R11 tei dropped", 0, 0, 0, 8'h00, '0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd1, 0, 8'h07);
        expect_pkt("R11 counter untouched", 184, 0, 0, 8'h07, '0);
    endtask

    task automatic t_reconfig();
        cfg_write(1, 13'h101, 1);
        clear_cap();
        send_pkt(8'h47, 13'h101, 0, 0, 2'b01, 4'd12, 0, 8'h90);
        expect_pkt("R12 history cleared", 184, 1, 0, 8'h90, '0);
        cfg_write(1, 13'h101, 0);
        clear_cap();
        send_pkt(8'h47, 13'h101, 0, 0, 2'b01, 4'd13, 0, 8'h90);
        expect_pkt("R12 slot disabled", 0, 0, 0, 8'h00, '0);
    endtask

    task automatic t_sync_loss();
        clear_cap();
        send_pkt(8'h00, 13'h100, 0, 1, 2'b01, 4'd2, 0, 8'h00);
        check(in_sync == 1'b0, "R2 sync lost", in_sync, 0);
        check(cap_n == 0, "R2 bad packet dropped", cap_n, 0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd9, 0, 8'h00);
        send_pkt(8'h47, 13'h100, 0, 0, 2'b01, 4'd9, 0, 8'h00);
        check(in_sync == 1'b0, "R1 relock pending", in_sync, 0);
        check(cap_n == 0, "R1 no output while hunting", cap_n, 0);
        clear_cap();
        send_pkt(8'h47, 13'h100, 0, 1, 2'b01, 4'd2, 0, 8'hA0);
        check(in_sync == 1'b1, "R1 relocked", in_sync, 1);
        expect_pkt("R1 first packet after relock", 184, 0, 1, 8'hA0, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_write(0, 13'h100, 1);
        cfg_write(1, 13'h101, 1);
        cfg_write(5, 13'h0AB, 1);
        cfg_write(7, 13'h0AB, 1);
        cfg_write(9, 13'h200, 0);
        t_acquire();
        t_audio();
        t_adapt();
        t_no_payload();
        t_filter();
        t_priority();
        t_cc();
        t_tei();
        t_reconfig();
        t_sync_loss();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule